// File: doc/BRIEF.md
# Debug Breakpoint Control and Status Unit

This block sits next to a CPU instruction decoder as the on-chip debug controller. It holds one writable control word and exposes one read-only status word through a small register port. Each cycle the decoder reports whether it is decoding an opcode, which opcode, and whether a data watchpoint has matched. The unit decides whether the breakpoint opcode (0x00) puts the core into debug mode or passes through as a no-operation.

On a breakpoint or watchpoint hit, and only when acknowledges are enabled, the unit raises a byte-send request carrying the fixed value 0xFF toward a serial transmitter. The request stays up until the transmitter accepts it. Further hits while it is pending are merged into it.

The control word also carries a system reset request. Writing it to 1 asks the rest of the chip to run a power-on style reset. The request clears itself when the chip reports that the reset has finished. Only the unit's own reset input clears its registers, so debug state survives the chip reset it requested.

Top module: `dbg_brk_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the control word reads 0x00, `dbg_mode`, `tx_req` and `sys_rst_req` are 0, and `reg_rdata` is 0x00. This also holds when `rst` is applied in the middle of operation.
- R2: Breakpoint enable is control bit 6. When it is 0, a decoded opcode 0x00 with `op_valid` high leaves `dbg_mode` unchanged and raises no send request.
- R3: When control bit 6 is 1, a decoded opcode 0x00 sets `dbg_mode` (control bit 7) on the next clock edge. Any other opcode value leaves it unchanged.
- R4: Acknowledge enable is control bit 5. When it is 1, a breakpoint hit (as in R3) or a `wp_hit` pulse raises `tx_req` on the next cycle with `tx_byte` = 0xFF. When it is 0, neither kind of hit raises `tx_req`. A watchpoint hit never changes `dbg_mode`.
- R5: `tx_req` stays high until a cycle with `tx_ack` high, and it is low on the cycle after that. A hit that arrives while the request is already pending does not produce a second request after the acknowledge.
- R6: Writing the control word with bit 0 set raises `sys_rst_req` on the next cycle. It stays high, even across writes with bit 0 clear, until a cycle with `sys_rst_done` high, and is low on the following cycle. Control bits 7, 6 and 5 keep their values throughout.
- R7: Control bits 4 to 1 ignore writes and always read as 0.
- R8: With `reg_addr` = 1, `reg_rdata` returns the status word one cycle later: bit 7 = `dbg_mode`, bit 6 = `core_halt`, bit 5 = `rd_prot`, bits 4 to 0 = 0. With `reg_addr` = 0 it returns the control word.
- R9: A host write to the control word sets or clears `dbg_mode` through bit 7. If a breakpoint hit arrives in the same cycle as a write, `dbg_mode` ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the debug unit only |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_addr | input | 1 | Read select: 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| op_valid | input | 1 | Decoder presents an opcode this cycle |
| op_code | input | 8 | Opcode being decoded |
| wp_hit | input | 1 | Watchpoint match pulse |
| core_halt | input | 1 | Core is halted |
| rd_prot | input | 1 | Memory read protection active |
| dbg_mode | output | 1 | Core is in debug mode |
| tx_req | output | 1 | Acknowledge byte pending toward transmitter |
| tx_byte | output | 8 | Byte to send (0xFF) |
| tx_ack | input | 1 | Transmitter accepted the byte |
| sys_rst_req | output | 1 | Reset request to the rest of the chip |
| sys_rst_done | input | 1 | Chip reset sequence has finished |

## Verification
The bench sends the breakpoint opcode both with the enable off and with it on, and checks that an enable treated as always on would show up as an unwanted debug entry. It lets a second hit arrive while a send is pending. A design that queues hits would then show a second request after the acknowledge. It writes 0 to the reset bit while a reset is pending and checks that the debug bits survive the reset's completion, which exposes a design that clears the request on any write or resets itself. It also sends a breakpoint in the same cycle as a write that clears debug mode, and writes all ones to check that the reserved bits stay at zero.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  localparam int unsigned REG_W   = 8;
  // control word bit positions
  localparam int unsigned CB_DBG  = 7;
  localparam int unsigned CB_BKEN = 6;
  localparam int unsigned CB_AKEN = 5;
  localparam int unsigned CB_SRST = 0;
  // status word bit positions
  localparam int unsigned SB_DBG  = 7;
  localparam int unsigned SB_HALT = 6;
  localparam int unsigned SB_RDP  = 5;
  localparam logic [REG_W-1:0] CTRL_RSV_MASK = 8'h1E;
  localparam logic [REG_W-1:0] STAT_RSV_MASK = 8'h1F;
endpackage

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg #(
  parameter int unsigned OPC_W = 8,
  parameter logic [OPC_W-1:0] BRK_OPCODE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_dbg,
  input  logic             wr_bken,
  input  logic             wr_aken,
  input  logic             wr_srst,
  input  logic             op_valid,
  input  logic [OPC_W-1:0] op_code,
  input  logic             sys_rst_done,
  output logic             dbg_mode,
  output logic             brk_en,
  output logic             ack_en,
  output logic             srst_req,
  output logic             brk_hit
);
  assign brk_hit = op_valid && (op_code == BRK_OPCODE) && brk_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_mode <= 1'b0;
      brk_en   <= 1'b0;
      ack_en   <= 1'b0;
      srst_req <= 1'b0;
    end else begin
      if (srst_req && sys_rst_done) srst_req <= 1'b0;
      if (wr_en) begin
        dbg_mode <= wr_dbg;
        brk_en   <= wr_bken;
        ack_en   <= wr_aken;
        if (wr_srst) srst_req <= 1'b1;
      end
      if (brk_hit) dbg_mode <= 1'b1;
    end
  end

  AST_NOP_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == BRK_OPCODE && !brk_en && !wr_en && !dbg_mode) |=> !dbg_mode); // R2
  AST_BRK_ENTERS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == BRK_OPCODE && brk_en) |=> dbg_mode); // R3
  AST_SRST_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (srst_req && !sys_rst_done) |=> srst_req); // R6
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (srst_req && sys_rst_done && !(wr_en && wr_srst)) |=> !srst_req); // R6
  AST_WRITE_CLEARS_DBG: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_dbg && !brk_hit) |=> !dbg_mode); // R9
endmodule

// File: rtl/dbg_ack_tx.sv
module dbg_ack_tx #(
  parameter int unsigned BYTE_W = 8,
  parameter logic [BYTE_W-1:0] ACK_BYTE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_en,
  input  logic              hit,
  input  logic              tx_ack,
  output logic              tx_req,
  output logic [BYTE_W-1:0] tx_byte
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else     pending <= (pending && !tx_ack) || (hit && ack_en);
  end

  assign tx_req  = pending;
  assign tx_byte = ACK_BYTE;

  AST_REQ_STICKS: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_ack) |=> (tx_req && tx_byte == ACK_BYTE)); // R5
  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
    (tx_req && tx_ack && !hit) |=> !tx_req); // R5
  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!ack_en && !tx_req) |=> !tx_req); // R4
  AST_HIT_REQUESTS: assert property (@(posedge clk) disable iff (rst)
    (hit && ack_en) |=> tx_req); // R4
endmodule

// File: rtl/dbg_reg_read.sv
module dbg_reg_read
  import dbg_brk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_stat,
  input  logic             dbg_mode,
  input  logic             brk_en,
  input  logic             ack_en,
  input  logic             srst_req,
  input  logic             core_halt,
  input  logic             rd_prot,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] ctrl_word, stat_word;

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[CB_DBG]  = dbg_mode;
    ctrl_word[CB_BKEN] = brk_en;
    ctrl_word[CB_AKEN] = ack_en;
    ctrl_word[CB_SRST] = srst_req;
    stat_word          = '0;
    stat_word[SB_DBG]  = dbg_mode;
    stat_word[SB_HALT] = core_halt;
    stat_word[SB_RDP]  = rd_prot;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel_stat ? stat_word : ctrl_word;
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdata & CTRL_RSV_MASK & STAT_RSV_MASK) == '0); // R7
  AST_STAT_DBG: assert property (@(posedge clk) disable iff (rst)
    sel_stat |=> (rdata[SB_DBG] == $past(dbg_mode))); // R8
endmodule

// File: rtl/dbg_brk_ctrl.sv
module dbg_brk_ctrl
  import dbg_brk_pkg::*;
#(
  parameter int unsigned OPC_W = 8,
  parameter logic [OPC_W-1:0] BRK_OPCODE = 8'h00,
  parameter logic [REG_W-1:0] ACK_BYTE = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             op_valid,
  input  logic [OPC_W-1:0] op_code,
  input  logic             wp_hit,
  input  logic             core_halt,
  input  logic             rd_prot,
  output logic             dbg_mode,
  output logic             tx_req,
  output logic [REG_W-1:0] tx_byte,
  input  logic             tx_ack,
  output logic             sys_rst_req,
  input  logic             sys_rst_done
);
  logic brk_en, ack_en, brk_hit;

  dbg_ctrl_reg #(.OPC_W(OPC_W), .BRK_OPCODE(BRK_OPCODE)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(reg_wr),
    .wr_dbg(reg_wdata[CB_DBG]), .wr_bken(reg_wdata[CB_BKEN]),
    .wr_aken(reg_wdata[CB_AKEN]), .wr_srst(reg_wdata[CB_SRST]),
    .op_valid(op_valid), .op_code(op_code), .sys_rst_done(sys_rst_done),
    .dbg_mode(dbg_mode), .brk_en(brk_en), .ack_en(ack_en),
    .srst_req(sys_rst_req), .brk_hit(brk_hit)
  );

  dbg_ack_tx #(.BYTE_W(REG_W), .ACK_BYTE(ACK_BYTE)) u_ack (
    .clk(clk), .rst(rst), .ack_en(ack_en), .hit(brk_hit || wp_hit),
    .tx_ack(tx_ack), .tx_req(tx_req), .tx_byte(tx_byte)
  );

  dbg_reg_read u_rd (
    .clk(clk), .rst(rst), .sel_stat(reg_addr), .dbg_mode(dbg_mode),
    .brk_en(brk_en), .ack_en(ack_en), .srst_req(sys_rst_req),
    .core_halt(core_halt), .rd_prot(rd_prot), .rdata(reg_rdata)
  );

  AST_WP_NO_DEBUG: assert property (@(posedge clk) disable iff (rst)
    (wp_hit && !op_valid && !reg_wr && !dbg_mode) |=> !dbg_mode); // R4
endmodule

// File: tb/tb_dbg_brk_ctrl.sv
module tb_dbg_brk_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 0, reg_addr = 0, op_valid = 0, wp_hit = 0, core_halt = 0, rd_prot = 0;
  logic tx_ack = 0, sys_rst_done = 0;
  logic [7:0] reg_wdata = '0, op_code = '0;
  logic [7:0] reg_rdata, tx_byte;
  logic dbg_mode, tx_req, sys_rst_req;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  dbg_brk_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .op_valid(op_valid), .op_code(op_code), .wp_hit(wp_hit),
    .core_halt(core_halt), .rd_prot(rd_prot), .dbg_mode(dbg_mode), .tx_req(tx_req),
    .tx_byte(tx_byte), .tx_ack(tx_ack), .sys_rst_req(sys_rst_req), .sys_rst_done(sys_rst_done)
  );

  typedef struct packed {
    logic we; logic [7:0] wd; logic opv; logic [7:0] opc; logic wp; logic ack; logic done;
    logic e_dbg; logic e_tx; logic e_rst; logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 NOP when off
    '{1'b1, 8'h40, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
    '{1'b0, 8'h00, 1'b1, 8'h3A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 other opcode
    '{1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3}, // R3 enter, R4 ack off
    '{1'b1, 8'h60, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 host clears
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 watchpoint
    '{1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5}, // R5 hit while pending
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5}, // R5 no duplicate
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},
    '{1'b1, 8'h60, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd9}, // R9 hit beats write
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},
    '{1'b1, 8'hE1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd6}, // R6 request
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd6},
    '{1'b1, 8'hE0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd6}, // R6 write 0 ignored
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd6}, // R6 done clears
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6},
    '{1'b1, 8'hC0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4}  // R4 ack disabled
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    reg_wr = 0; reg_wdata = '0; op_valid = 0; op_code = '0; wp_hit = 0;
    tx_ack = 0; sys_rst_done = 0;
  endtask

  task automatic read_reg(input logic a, input logic [7:0] exp, input string tag);
    idle_inputs(); reg_addr = a;
    @(negedge clk);
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 dbg_mode", {7'd0, dbg_mode}, 8'h00);
    check("R1 tx_req", {7'd0, tx_req}, 8'h00);
    check("R1 sys_rst_req", {7'd0, sys_rst_req}, 8'h00);
    check("R1 rdata", reg_rdata, 8'h00);
    read_reg(1'b1, 8'h00, "R1 status");

    for (int i = 0; i < NV; i++) begin
      reg_wr = VEC[i].we; reg_wdata = VEC[i].wd; op_valid = VEC[i].opv; op_code = VEC[i].opc;
      wp_hit = VEC[i].wp; tx_ack = VEC[i].ack; sys_rst_done = VEC[i].done;
      @(negedge clk);
      check($sformatf("R%0d dbg_mode v%0d", VEC[i].req, i), {7'd0, dbg_mode}, {7'd0, VEC[i].e_dbg});
      check($sformatf("R%0d tx_req v%0d", VEC[i].req, i), {7'd0, tx_req}, {7'd0, VEC[i].e_tx});
      check($sformatf("R%0d sys_rst_req v%0d", VEC[i].req, i), {7'd0, sys_rst_req}, {7'd0, VEC[i].e_rst});
      if (tx_req) check("R4 tx_byte", tx_byte, 8'hFF);
    end

    // R7: all-ones write, reserved bits read 0
    idle_inputs(); reg_wr = 1; reg_wdata = 8'hFF;
    @(negedge clk);
    read_reg(1'b0, 8'hE1, "R7 control readback");
    // finish the reset request, control bits keep value (R6)
    sys_rst_done = 1; @(negedge clk);
    read_reg(1'b0, 8'hE0, "R6 control after done");
    // R8 status fields
    core_halt = 1; rd_prot = 1;
    read_reg(1'b1, 8'hE0, "R8 status all set");
    core_halt = 0; rd_prot = 0;
    read_reg(1'b1, 8'h80, "R8 status dbg only");
    core_halt = 1;
    idle_inputs(); reg_wr = 1; reg_wdata = 8'h00; @(negedge clk);
    read_reg(1'b1, 8'h40, "R8 status halt only");
    core_halt = 0;
    // R1: mid-run reset clears control
    idle_inputs(); reg_wr = 1; reg_wdata = 8'hE1; @(negedge clk);
    idle_inputs(); rst = 1; @(negedge clk); rst = 0;
    check("R1 midrun dbg_mode", {7'd0, dbg_mode}, 8'h00);
    check("R1 midrun sys_rst_req", {7'd0, sys_rst_req}, 8'h00);
    read_reg(1'b0, 8'h00, "R1 midrun control");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule